// File: doc/BRIEF.md
# Trilevel HDTV Sync Pulse Generator

This block chooses the sync level that an HDTV video encoder's output converter should drive on each line. It watches an active-low horizontal sync input. When that input falls, the block plays out one timed pulse. In the two high-definition formats the pulse has three levels: a low phase, then a high phase of the same length, then a return to blanking. The length is 44 clocks for the interlaced 1080-line format and 40 clocks for the progressive 720-line format. In the standard-definition progressive formats the pulse has only two levels: a low phase of a configurable length, then blanking.

The downstream converter turns the 2-bit level code into voltages. Those voltages are -300 mV, 0 mV and +300 mV, each raised by 350 mV, which gives 50 mV, 350 mV and 650 mV. A busy flag marks the clocks on which a pulse is in progress. The format is sampled only when a pulse starts, so software may rewrite it at any time.

Top module: `trisync_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no edge seen, `level` is 00 (blank) and `busy` is 0.
- R2: A high-to-low transition on `hsync_n` starts a pulse. `hsync_n` passes through two synchronizer flops and one edge register, so the first low code appears after the third rising clock edge following the fall. A low-to-high transition starts nothing.
- R3: With `raster_sel` = 2'b10, the pulse is `LEN_1080` (44) clocks of code 01, then `LEN_1080` clocks of code 10, then 00.
- R4: With `raster_sel` = 2'b11, the pulse is `LEN_720` (40) clocks of code 01, then `LEN_720` clocks of code 10, then 00.
- R5: With `raster_sel` = 2'b00 or 2'b01, the pulse is `LEN_SD` (64) clocks of code 01, then 00, and code 10 never appears.
- R6: `level` takes only the codes 00 (blank), 01 (low sync) and 10 (high sync). Code 11 never appears.
- R7: `busy` is 1 on exactly the clocks where `level` is not 00.
- R8: A falling edge on `hsync_n` that arrives while a pulse is running is ignored. The running pulse keeps its length, and no second pulse follows it.
- R9: `raster_sel` is sampled only at the start of a pulse. Changing it during a pulse does not alter that pulse, and the new value applies to the next pulse.
- R10: Every pulse begins with code 01, and code 10 only ever follows code 01 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low, asynchronous to `clk` |
| raster_sel | input | 2 | Format: 00/01 standard-definition two-level, 10 = 1080i, 11 = 720p |
| level | output | 2 | Sync level code: 00 blank, 01 low, 10 high |
| busy | output | 1 | High while a pulse is being produced |

## Verification
Two cases are hard to reach from the ports: a second sync fall landing in the middle of a running pulse, and a format change that lands after a pulse has already latched its format. The stimulus creates both on purpose. It raises and then lowers `hsync_n` again a few clocks into the low phase. In a separate run, it flips `raster_sel` between the two-level and three-level families partway through the pulse. The bench then counts every low and high clock over a window long enough to expose a restarted or stretched pulse. These runs are swept across all four format codes, both with and without the disturbance.

// File: rtl/trisync_gen.sv
module trisync_gen #(
  parameter int LEN_1080 = 44,
  parameter int LEN_720  = 40,
  parameter int LEN_SD   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_n,
  input  logic [1:0] raster_sel,
  output logic [1:0] level,
  output logic       busy
);

  localparam int MAXL = (LEN_SD > LEN_1080) ? ((LEN_SD > LEN_720) ? LEN_SD : LEN_720)
                                            : ((LEN_1080 > LEN_720) ? LEN_1080 : LEN_720);
  localparam int CW = $clog2(MAXL + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_t;

  st_t           st;
  logic [2:0]    hs_q;
  logic [CW-1:0] cnt, len_q, len_sel;
  logic          tri_q;

  wire fall = hs_q[2] & ~hs_q[1];

  assign len_sel = raster_sel[1] ? (raster_sel[0] ? CW'(LEN_720) : CW'(LEN_1080)) : CW'(LEN_SD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 3'b111;
      st    <= ST_IDLE;
      cnt   <= '0;
      len_q <= '0;
      tri_q <= 1'b0;
    end else begin
      hs_q <= {hs_q[1:0], hsync_n};
      case (st)
        ST_IDLE: if (fall) begin
          st    <= ST_LOW;
          cnt   <= len_sel - 1'b1;
          len_q <= len_sel;
          tri_q <= raster_sel[1];
        end
        ST_LOW: begin
          if (cnt == '0) begin
            if (tri_q) begin
              st  <= ST_HIGH;
              cnt <= len_q - 1'b1;
            end else begin
              st  <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign level = (st == ST_LOW) ? 2'b01 : (st == ST_HIGH) ? 2'b10 : 2'b00;
  assign busy  = (st != ST_IDLE);

endmodule

// File: rtl/trisync_chk.sv
module trisync_chk #(
  parameter int MAXL = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] level,
  input logic       busy
);

  logic [1:0]  prv;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv <= 2'b00;
      run <= '0;
    end else begin
      prv <= level;
      if (level != prv)   run <= 16'd1;
      else if (run != '1) run <= run + 16'd1;
    end
  end

  AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n) level != 2'b11); // R6
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) busy == (level != 2'b00)); // R7
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> level == 2'b01); // R10
  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b10 && prv != 2'b10) |-> prv == 2'b01); // R10
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (level != 2'b00 && level == prv) |-> run < 16'(MAXL)); // R3

endmodule

bind trisync_gen trisync_chk #(
  .MAXL((LEN_SD > LEN_1080) ? ((LEN_SD > LEN_720) ? LEN_SD : LEN_720)
                            : ((LEN_1080 > LEN_720) ? LEN_1080 : LEN_720))
) u_chk (
  .clk(clk), .rst_n(rst_n), .level(level), .busy(busy)
);

// File: tb/sim_trisync_gen.sv
`timescale 1ns/1ps
module sim_trisync_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_n = 1'b1;
  logic [1:0] raster_sel = 2'b00;
  logic [1:0] level;
  logic       busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  trisync_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n),
    .raster_sel(raster_sel), .level(level), .busy(busy)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pulse(input logic [1:0] sel, input int disturb);
    int lo = 0, hi = 0, first = -1, bad_ord = 0, bad_busy = 0;
    int exp_lo, exp_hi;
    string rq, dq;
    exp_lo = sel[1] ? (sel[0] ? 40 : 44) : 64;
    exp_hi = sel[1] ? exp_lo : 0;
    rq = sel[1] ? (sel[0] ? "R4" : "R3") : "R5";
    dq = (disturb == 1) ? "R8" : (disturb == 2) ? "R9" : rq;
    @(negedge clk);
    raster_sel = sel;
    hsync_n = 1'b0;
    for (int i = 1; i <= 220; i++) begin
      @(negedge clk);
      if (level == 2'b01) begin
        lo++;
        if (first < 0) first = i;
        if (hi > 0) bad_ord++;
      end else if (level == 2'b10) begin
        hi++;
        if (lo == 0) bad_ord++;
      end else if (level == 2'b11) begin
        bad_ord++;
      end
      if (busy != (level != 2'b00)) bad_busy++;
      if (disturb == 1 && i == 5)  hsync_n = 1'b1;
      if (disturb == 1 && i == 12) hsync_n = 1'b0;
      if (disturb == 2 && i == 8)  raster_sel = sel ^ 2'b10;
    end
    chk(first == 3, "R2 start latency", first, 3);
    chk(lo == exp_lo, {dq, " low length"}, lo, exp_lo);
    chk(hi == exp_hi, {dq, " high length"}, hi, exp_hi);
    chk(bad_ord == 0, "R10 R6 level order", bad_ord, 0);
    chk(bad_busy == 0, "R7 busy", bad_busy, 0);
    hsync_n = 1'b1;
    for (int i = 0; i < 8; i++) @(negedge clk);
    chk(level == 2'b00 && !busy, "R2 rising edge starts nothing", int'(level), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(level == 2'b00, "R1 level in reset", int'(level), 0);
    chk(!busy, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(level == 2'b00 && !busy, "R1 idle after reset", int'(level), 0);
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 4; s++)
        run_pulse(2'(s), d);
    // reset in the middle of a pulse
    @(negedge clk);
    raster_sel = 2'b10;
    hsync_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(level == 2'b00 && !busy, "R1 reset mid-pulse", int'(level), 0);
    rst_n = 1'b1;
    hsync_n = 1'b1;
    repeat (4) @(negedge clk);
    run_pulse(2'b11, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule